// File: doc/BRIEF.md
# Message Bus Register Target

This block sits on the PHY side of a MAC-to-PHY link and hosts a bank of 8-bit registers. The MAC reaches it over two byte-wide buses that share one interface clock: an inbound bus carrying commands and an outbound bus carrying responses. Each inbound transaction is a short train of beats. The first beat holds a command code and the top of a 12-bit address. The second beat holds the rest of the address. Write commands add a third beat that carries the data byte.

Writes come in two kinds. An uncommitted write is only held in a small staging buffer. A committed write adds itself to the end of the staged set, and then every staged write lands in the register bank in a single clock, in the order the writes arrived. Only the committed write is acknowledged. A read is answered with a completion beat followed by the data beat.

The 12-bit address space has four equal regions: receive, transmit, common and vendor. Each region implements a parameterised number of registers, starting at its offset 0. The rest of the chip sees every register on a flat output, together with one write strobe per register.

Top module: `msgbus_reg_target`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, msg_out is 0x00, every register reads 0x00, reg_wr_strobe is all zero and stage_ovf is 0.
- R2: Beat 0 of a command carries the code in bits [7:4] and address bits [11:8] in bits [3:0]. Beat 1 carries address bits [7:0]. For a write, beat 2 carries the data. A beat whose bits [7:4] are 0 is idle, whatever bits [3:0] hold. The next command may start in the cycle right after the previous command's last beat.
- R3: A read (code 3) puts the completion beat 0x40 on msg_out in the cycle after its address beat, and the register's data byte on msg_out in the cycle after that.
- R4: An uncommitted write (code 1) changes no register and no strobe until a later committed write arrives.
- R5: A committed write (code 2) applies every staged write in arrival order, and then its own write, all in one clock. When several writes hit the same address, the last one wins. The new values appear in the cycle after the committed write's data beat, and the staging buffer is left empty.
- R6: A committed write produces exactly one acknowledge beat, 0x50, on msg_out two cycles after its data beat. Uncommitted writes produce no outbound beat.
- R7: Address bits [11:10] select the region (0 receive, 1 transmit, 2 common, 3 vendor). Offsets 0 to RGN_REGS-1 are implemented. The register with index region*RGN_REGS+offset is driven on reg_flat bits [8*index+7 : 8*index].
- R8: A read of an address that is not implemented returns data 0x00. A write to such an address is dropped, but a committed write to it is still acknowledged.
- R9: When a write arrives at a full staging buffer (STAGE_DEPTH entries), the oldest staged entry is discarded and stage_ovf is set in the next cycle. stage_ovf stays set until reset.
- R10: A beat 0 whose code is not 1, 2 or 3 (including 4, 5 and 6 to 15) is ignored. It produces no outbound beat, and the next beat is again taken as beat 0.
- R11: reg_wr_strobe bit i is high for exactly the one cycle in which a committed update first shows register i, and is low at all other times.
- R12: Back-to-back reads and writes with no idle beat between them are all decoded and answered, each at its own fixed delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msg_in | input | 8 | Inbound command/address/data beats |
| msg_out | output | 8 | Outbound completion, data and acknowledge beats |
| reg_flat | output | 4*RGN_REGS*8 | Contents of all implemented registers, byte i = register i |
| reg_wr_strobe | output | 4*RGN_REGS | One-cycle pulse per register updated by a commit |
| stage_ovf | output | 1 | Sticky staging-buffer overflow flag |

## Verification
Every result has a fixed latency counted from the beat that triggers it. The read completion is due one cycle after the address beat and the read data two cycles after it. The acknowledge is due two cycles after a committed write's data beat. Register contents, strobes and the overflow flag are due one cycle after the data beat that changes them. When the driver sends a beat, it stamps each expected outbound byte and each register snapshot with the exact cycle number it is due in. The monitor compares only in that cycle, flags any non-idle beat that nothing predicted, and flags any expected beat whose cycle passes without it.

// File: rtl/msgbus_pkg.sv
// Shared types for the message bus register target: command codes,
// region codes and the staged write item.
package msgbus_pkg;

    typedef enum logic [3:0] {
        CMD_IDLE      = 4'h0,
        CMD_WR_STAGE  = 4'h1,
        CMD_WR_COMMIT = 4'h2,
        CMD_RD        = 4'h3,
        CMD_RD_CPL    = 4'h4,
        CMD_WR_ACK    = 4'h5
    } cmd_e;

    typedef enum logic [1:0] {
        RGN_RX     = 2'd0,
        RGN_TX     = 2'd1,
        RGN_COMMON = 2'd2,
        RGN_VENDOR = 2'd3
    } region_e;

    typedef struct packed {
        logic [11:0] addr;
        logic [7:0]  data;
    } wr_item_t;

endpackage

// File: rtl/msgbus_beat_decoder.sv
// Splits the inbound byte stream into commands.
// Assumes: one beat per clock; unknown codes in beat 0 are dropped.
// The valid outputs are combinational and fire during the last beat of a command.
module msgbus_beat_decoder
    import msgbus_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  rx_byte,
    output logic        stage_vld,
    output logic        commit_vld,
    output wr_item_t    wr_item,
    output logic        rd_vld,
    output logic [11:0] rd_addr
);

    typedef enum logic [1:0] {PH_CMD, PH_ADDR, PH_DATA} phase_e;

    phase_e     ph;
    cmd_e       cmd_q;
    logic [3:0] ahi_q;
    logic [7:0] alo_q;
    logic [3:0] code;

    assign code = rx_byte[7:4];

    // Beat phase tracking and capture of code and address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph    <= PH_CMD;
            cmd_q <= CMD_IDLE;
            ahi_q <= '0;
            alo_q <= '0;
        end else begin
            case (ph)
                PH_CMD: begin
                    if (code == CMD_WR_STAGE || code == CMD_WR_COMMIT || code == CMD_RD) begin
                        cmd_q <= cmd_e'(code);
                        ahi_q <= rx_byte[3:0];
                        ph    <= PH_ADDR;
                    end
                end
                PH_ADDR: begin
                    alo_q <= rx_byte;
                    ph    <= (cmd_q == CMD_RD) ? PH_CMD : PH_DATA;
                end
                default: ph <= PH_CMD;
            endcase
        end
    end

    // Command strobes, valid during the final beat of each command.
    always_comb begin
        rd_vld       = (ph == PH_ADDR) && (cmd_q == CMD_RD);
        rd_addr      = {ahi_q, rx_byte};
        stage_vld    = (ph == PH_DATA) && (cmd_q == CMD_WR_STAGE);
        commit_vld   = (ph == PH_DATA) && (cmd_q == CMD_WR_COMMIT);
        wr_item.addr = {ahi_q, alo_q};
        wr_item.data = rx_byte;
    end

endmodule

// File: rtl/msgbus_stage_fifo.sv
// Holds uncommitted writes in arrival order (entry 0 is the oldest).
// Assumes: push and clear never come together; DEPTH >= 2.
// A push into a full buffer drops the oldest entry and sets a sticky flag.
module msgbus_stage_fifo
    import msgbus_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  push,
    input  wr_item_t              push_item,
    input  logic                  clear,
    output wr_item_t [DEPTH-1:0]  items,
    output logic [DEPTH-1:0]      item_vld,
    output logic                  ovf
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = $clog2(DEPTH);

    logic [CNT_W-1:0] cnt;

    // Entry storage, fill count and sticky overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            items <= '0;
            cnt   <= '0;
            ovf   <= 1'b0;
        end else if (clear) begin
            cnt <= '0;
        end else if (push) begin
            if (cnt == CNT_W'(DEPTH)) begin
                for (int i = 0; i < DEPTH - 1; i++) items[i] <= items[i+1];
                items[DEPTH-1] <= push_item;
                ovf            <= 1'b1;
            end else begin
                items[IDX_W'(cnt)] <= push_item;
                cnt                <= cnt + 1'b1;
            end
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_vld
        assign item_vld[g] = (CNT_W'(g) < cnt);
    end

endmodule

// File: rtl/msgbus_reg_bank.sv
// Register bank covering four address regions, each with RGN_REGS
// implemented registers at offsets 0..RGN_REGS-1.
// On a commit, the staged writes are applied in order and then the commit's own write.
// Assumes: addresses outside the implemented offsets read as 0 and ignore writes.
module msgbus_reg_bank
    import msgbus_pkg::*;
#(
    parameter int RGN_REGS = 4,
    parameter int DEPTH    = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          commit,
    input  wr_item_t                      commit_item,
    input  wr_item_t [DEPTH-1:0]          stg_items,
    input  logic [DEPTH-1:0]              stg_vld,
    input  logic [11:0]                   rd_addr,
    output logic [7:0]                    rd_data,
    output logic [4*RGN_REGS-1:0][7:0]    regs_q,
    output logic [4*RGN_REGS-1:0]         strobe_q
);

    localparam int NREGS = 4 * RGN_REGS;
    localparam int IDX_W = $clog2(NREGS);

    logic [NREGS-1:0][7:0] regs_d;
    logic [NREGS-1:0]      strobe_d;

    function automatic logic is_hit(input logic [11:0] a);
        return 32'(a[9:0]) < RGN_REGS;
    endfunction

    function automatic logic [IDX_W-1:0] idx_of(input logic [11:0] a);
        return IDX_W'(32'(a[11:10]) * RGN_REGS + 32'(a[9:0]));
    endfunction

    // Next register state: staged writes in order, then the commit's own write.
    always_comb begin
        regs_d   = regs_q;
        strobe_d = '0;
        if (commit) begin
            for (int j = 0; j < DEPTH; j++) begin
                if (stg_vld[j] && is_hit(stg_items[j].addr)) begin
                    regs_d[idx_of(stg_items[j].addr)]   = stg_items[j].data;
                    strobe_d[idx_of(stg_items[j].addr)] = 1'b1;
                end
            end
            if (is_hit(commit_item.addr)) begin
                regs_d[idx_of(commit_item.addr)]   = commit_item.data;
                strobe_d[idx_of(commit_item.addr)] = 1'b1;
            end
        end
    end

    // Read lookup; unimplemented addresses return zero.
    always_comb begin
        rd_data = is_hit(rd_addr) ? regs_q[idx_of(rd_addr)] : 8'h00;
    end

    // Register and strobe storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q   <= '0;
            strobe_q <= '0;
        end else begin
            regs_q   <= regs_d;
            strobe_q <= strobe_d;
        end
    end

endmodule

// File: rtl/msgbus_responder.sv
// Drives the outbound bus. A read sends a completion beat, then a data beat.
// A commit sends one acknowledge beat two cycles after its data beat.
// Assumes: the inbound framing keeps these beats from ever colliding.
module msgbus_responder
    import msgbus_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd_vld,
    input  logic [11:0] rd_addr,
    input  logic        commit_vld,
    input  logic [7:0]  rd_data,
    output logic [11:0] rd_addr_q,
    output logic [7:0]  tx_byte
);

    logic data_pend;
    logic ack_pend;

    // Outbound beat sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_byte   <= 8'h00;
            data_pend <= 1'b0;
            ack_pend  <= 1'b0;
            rd_addr_q <= '0;
        end else begin
            data_pend <= rd_vld;
            ack_pend  <= commit_vld;
            tx_byte   <= 8'h00;
            if (rd_vld) begin
                tx_byte   <= {CMD_RD_CPL, 4'h0};
                rd_addr_q <= rd_addr;
            end else if (data_pend) begin
                tx_byte <= rd_data;
            end else if (ack_pend) begin
                tx_byte <= {CMD_WR_ACK, 4'h0};
            end
        end
    end

endmodule

// File: rtl/msgbus_reg_target.sv
// Top of the message bus register target: beat decoder, staging buffer,
// register bank and responder.
// Assumes: the interface clock runs whenever the bus is in use.
module msgbus_reg_target
    import msgbus_pkg::*;
#(
    parameter int RGN_REGS    = 4,
    parameter int STAGE_DEPTH = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [7:0]                msg_in,
    output logic [7:0]                msg_out,
    output logic [4*RGN_REGS*8-1:0]   reg_flat,
    output logic [4*RGN_REGS-1:0]     reg_wr_strobe,
    output logic                      stage_ovf
);

    logic                           stage_vld;
    logic                           commit_vld;
    logic                           rd_vld;
    wr_item_t                       wr_item;
    logic [11:0]                    rd_addr;
    logic [11:0]                    rd_addr_q;
    logic [7:0]                     rd_data;
    wr_item_t [STAGE_DEPTH-1:0]     stg_items;
    logic [STAGE_DEPTH-1:0]         stg_vld;
    logic [4*RGN_REGS-1:0][7:0]     regs_q;

    msgbus_beat_decoder u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_byte    (msg_in),
        .stage_vld  (stage_vld),
        .commit_vld (commit_vld),
        .wr_item    (wr_item),
        .rd_vld     (rd_vld),
        .rd_addr    (rd_addr)
    );

    msgbus_stage_fifo #(.DEPTH(STAGE_DEPTH)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (stage_vld),
        .push_item (wr_item),
        .clear     (commit_vld),
        .items     (stg_items),
        .item_vld  (stg_vld),
        .ovf       (stage_ovf)
    );

    msgbus_reg_bank #(.RGN_REGS(RGN_REGS), .DEPTH(STAGE_DEPTH)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit      (commit_vld),
        .commit_item (wr_item),
        .stg_items   (stg_items),
        .stg_vld     (stg_vld),
        .rd_addr     (rd_addr_q),
        .rd_data     (rd_data),
        .regs_q      (regs_q),
        .strobe_q    (reg_wr_strobe)
    );

    msgbus_responder u_resp (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_vld     (rd_vld),
        .rd_addr    (rd_addr),
        .commit_vld (commit_vld),
        .rd_data    (rd_data),
        .rd_addr_q  (rd_addr_q),
        .tx_byte    (msg_out)
    );

    assign reg_flat = regs_q;

endmodule

// File: rtl/msgbus_reg_target_chk.sv
// Protocol checker for msgbus_reg_target, attached through bind.
// Looks at the decoded command strobes and the outbound behaviour.
module msgbus_reg_target_chk #(
    parameter int NREGS = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       msg_out,
    input logic             commit_vld,
    input logic             stage_vld,
    input logic             rd_vld,
    input logic [NREGS-1:0] reg_wr_strobe,
    input logic             stage_ovf
);

    assert_cpl_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vld |=> (msg_out == 8'h40));

    assert_ack_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
        commit_vld |=> ##1 (msg_out == 8'h50));

    assert_stage_no_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stage_vld |=> (reg_wr_strobe == '0));

    assert_strobe_from_commit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (|reg_wr_strobe) |-> $past(commit_vld));

    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(stage_ovf));

endmodule

bind msgbus_reg_target msgbus_reg_target_chk #(.NREGS(4 * RGN_REGS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .msg_out       (msg_out),
    .commit_vld    (commit_vld),
    .stage_vld     (stage_vld),
    .rd_vld        (rd_vld),
    .reg_wr_strobe (reg_wr_strobe),
    .stage_ovf     (stage_ovf)
);

// File: tb/tb_msgbus_reg_target.sv
// Scoreboard bench: driver tasks push time-stamped expectations, monitor compares.
module tb_msgbus_reg_target;

    localparam int RGN_REGS = 4;
    localparam int DEPTH    = 4;
    localparam int NREGS    = 4 * RGN_REGS;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [7:0]           msg_in = 8'h00;
    logic [7:0]           msg_out;
    logic [NREGS*8-1:0]   reg_flat;
    logic [NREGS-1:0]     reg_wr_strobe;
    logic                 stage_ovf;

    msgbus_reg_target #(.RGN_REGS(RGN_REGS), .STAGE_DEPTH(DEPTH)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .msg_in        (msg_in),
        .msg_out       (msg_out),
        .reg_flat      (reg_flat),
        .reg_wr_strobe (reg_wr_strobe),
        .stage_ovf     (stage_ovf)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int         at;
        logic [7:0] val;
        string      tag;
    } exp_t;

    exp_t             expq[$];
    int               errors = 0;
    int               checks = 0;
    bit               finished = 0;
    logic [7:0]       model[NREGS];
    logic [11:0]      stq_a[$];
    logic [7:0]       stq_d[$];
    bit               m_ovf = 0;
    int               reg_chk_at = -1;
    logic [NREGS-1:0] exp_strb = '0;
    string            reg_tag = "R5";

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit is_hit(input logic [11:0] a);
        return 32'(a[9:0]) < RGN_REGS;
    endfunction

    function automatic int idx_of(input logic [11:0] a);
        return 32'(a[11:10]) * RGN_REGS + 32'(a[9:0]);
    endfunction

    function automatic logic [NREGS*8-1:0] model_flat();
        logic [NREGS*8-1:0] f;
        for (int i = 0; i < NREGS; i++) f[8*i +: 8] = model[i];
        return f;
    endfunction

    task automatic beat(input logic [7:0] b);
        @(negedge clk);
        msg_in = b;
    endtask

    task automatic push_exp(input int at, input logic [7:0] v, input string tag);
        exp_t e;
        e.at = at; e.val = v; e.tag = tag;
        expq.push_back(e);
    endtask

    // R3: completion one cycle after the address beat, data one cycle later.
    task automatic do_read(input logic [11:0] a, input string tag);
        beat({4'h3, a[11:8]});
        beat(a[7:0]);
        push_exp(cyc + 1, 8'h40, tag);
        push_exp(cyc + 2, is_hit(a) ? model[idx_of(a)] : 8'h00, tag);
    endtask

    // R4: an uncommitted write is only staged; R9: the oldest is dropped when full.
    task automatic do_stage(input logic [11:0] a, input logic [7:0] d);
        beat({4'h1, a[11:8]});
        beat(a[7:0]);
        beat(d);
        stq_a.push_back(a);
        stq_d.push_back(d);
        if (stq_a.size() > DEPTH) begin
            void'(stq_a.pop_front());
            void'(stq_d.pop_front());
            m_ovf = 1;
        end
    endtask

    // R5: staged writes in order, then own write; R6: ack two cycles later.
    task automatic do_commit(input logic [11:0] a, input logic [7:0] d, input string tag);
        beat({4'h2, a[11:8]});
        beat(a[7:0]);
        beat(d);
        exp_strb = '0;
        for (int i = 0; i < stq_a.size(); i++) begin
            if (is_hit(stq_a[i])) begin
                model[idx_of(stq_a[i])]    = stq_d[i];
                exp_strb[idx_of(stq_a[i])] = 1'b1;
            end
        end
        if (is_hit(a)) begin
            model[idx_of(a)]    = d;
            exp_strb[idx_of(a)] = 1'b1;
        end
        stq_a.delete();
        stq_d.delete();
        reg_tag    = tag;
        reg_chk_at = cyc + 1;
        push_exp(cyc + 2, 8'h50, tag);
    endtask

    // Monitor: compares outbound beats and register snapshots in their due cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            if (expq.size() > 0 && expq[0].at < cyc) begin
                chk(0, expq[0].tag, "missed beat", msg_out, expq[0].val);
                void'(expq.pop_front());
            end
            if (expq.size() > 0 && expq[0].at == cyc) begin
                chk(msg_out == expq[0].val, expq[0].tag, "outbound beat", msg_out, expq[0].val);
                void'(expq.pop_front());
            end else if (msg_out != 8'h00) begin
                chk(0, "R10", "unexpected outbound beat", msg_out, 8'h00);
            end
            if (cyc == reg_chk_at) begin
                chk(reg_flat == model_flat(), reg_tag, "registers after commit (R7 layout)",
                    reg_flat, model_flat());
                chk(reg_wr_strobe == exp_strb, "R11", "write strobes", reg_wr_strobe, exp_strb);
                chk(stage_ovf == m_ovf, "R9", "overflow flag", stage_ovf, m_ovf);
            end else if (reg_wr_strobe != '0) begin
                chk(0, "R11", "strobe outside commit cycle", reg_wr_strobe, '0);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "R12", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        for (int i = 0; i < NREGS; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1: reset state while reset is held
        chk(msg_out == 8'h00, "R1", "msg_out in reset", msg_out, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk(msg_out == 8'h00, "R1", "msg_out after reset", msg_out, 8'h00);
        chk(reg_flat == '0, "R1", "registers after reset", reg_flat, 0);
        chk(reg_wr_strobe == '0, "R1", "strobes after reset", reg_wr_strobe, 0);
        chk(stage_ovf == 1'b0, "R1", "overflow after reset", stage_ovf, 0);

        do_read(12'h001, "R3");
        // R4: staged values stay invisible until commit
        do_stage(12'h001, 8'hA1);
        do_stage(12'h402, 8'hB2);
        do_read(12'h001, "R4");
        do_commit(12'h803, 8'hC3, "R5");
        do_read(12'h001, "R5");
        do_read(12'h402, "R5");
        do_read(12'h803, "R12");
        // R5: arrival order, last write to the same address wins
        do_stage(12'h002, 8'h11);
        do_stage(12'h002, 8'h22);
        do_commit(12'h003, 8'h33, "R5");
        do_read(12'h002, "R5");
        do_stage(12'h003, 8'h44);
        do_commit(12'h003, 8'h55, "R5");
        do_read(12'h003, "R5");
        // R10: unknown and response-only codes are ignored; R2: 0x0F is idle
        beat(8'h6A);
        beat(8'h4F);
        beat(8'h5F);
        beat(8'hF0);
        beat(8'h0F);
        beat(8'h00);
        do_read(12'h003, "R10");
        do_read(12'h402, "R2");
        // R8: unimplemented addresses
        do_stage(12'h004, 8'h77);
        do_commit(12'hFFF, 8'h88, "R8");
        do_read(12'h004, "R8");
        do_read(12'h3FF, "R8");
        // R7: each region maps to its own register slice
        do_commit(12'hC00, 8'h9C, "R7");
        do_commit(12'h401, 8'h9B, "R7");
        do_read(12'hC00, "R7");
        do_read(12'h401, "R7");
        do_read(12'h800, "R7");
        // R9: overflow drops the oldest staged write
        do_stage(12'h400, 8'hE0);
        do_stage(12'h401, 8'hE1);
        do_stage(12'h402, 8'hE2);
        do_stage(12'h403, 8'hE3);
        do_stage(12'h800, 8'hE4);
        beat(8'h00);
        chk(stage_ovf == 1'b1, "R9", "overflow set", stage_ovf, 1);
        do_commit(12'h801, 8'hE9, "R9");
        do_read(12'h400, "R9");
        do_read(12'h401, "R9");
        do_read(12'h800, "R12");
        beat(8'h00);
        repeat (6) @(negedge clk);
        chk(expq.size() == 0, "R12", "pending expected beats", expq.size(), 0);
        chk(stage_ovf == 1'b1, "R9", "overflow still set", stage_ovf, 1);
        finish_run();
    end

endmodule